// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable behavioural model of a 1 Kbit serial nonvolatile memory that answers a three-wire protocol: a chip select, a serial clock and a data input, with a data output that carries its own output enable. A host raises the select, clocks in a start bit, a two-bit command code, an address and, for storing commands, a data value. The block reads, writes and erases single locations, fills or clears the whole array, and opens or closes a protection latch that gates every storing command.

The array can be viewed as 128 bytes or as 64 sixteen-bit words; a configuration input picks the view, and with it the address and data widths of each frame. Programming is self-timed: a counter in the system clock domain stands in for the long programming time, and the host may drop the select at any point without stopping it. After a storing command, a fresh rise of the select shows the busy or ready state on the data output.

The serial inputs are brought into the system clock domain through a short synchronizer chain, and serial clock rising edges are detected there, so the serial clock must be several system clocks long in each phase.

Top module: `tw_eeprom_slave`

## Requirements
- R1: With select high and no frame in progress, serial clock edges that sample a 0 on the data input leave the block idle; the first sampled 1 starts a frame.
- R2: The two bits after the start bit form the command code: 2'b10 read, 2'b01 write, 2'b11 erase, 2'b00 special; for a special code, the two most significant address bits pick 2'b11 enable, 2'b00 disable, 2'b10 erase-all, 2'b01 write-all.
- R3: With the configuration input at 0 the frame carries a 7-bit byte address and 8-bit data, and byte address bit 0 = 0 selects the low byte of word (address >> 1); at 1 it carries a 6-bit word address and 16-bit data. Fields are sent most significant bit first.
- R4: A read drives a 0 on the output at the edge that takes in the last address bit, then the addressed value MSB first, one bit per serial clock rise; further clocks continue at the next address.
- R5: The protection latch is closed after reset and after a disable command; while closed, write, erase, erase-all and write-all change nothing and arm no status.
- R6: Write stores the received value at the address; erase sets the addressed location to all ones.
- R7: Erase-all sets every location to all ones; write-all clears the array and leaves every location holding the received value.
- R8: After an accepted storing command, raising the select after a low period enables the output with 0 while programming runs and 1 once it has finished; programming lasts the parameter's number of system clocks.
- R9: Programming runs to completion while the select is low.
- R10: A low select aborts any frame; the output enable is low except during read data and the armed status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; bits taken on its rising edge |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organization: 0 bytes, 1 sixteen-bit words |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Each serial clock rise reaches the frame logic two system clocks after the pin changes and acts on the next edge, so a read bit, the dummy 0 or a new output-enable state appears about four system clocks after the rise; the bench holds each serial clock phase for six system clocks and samples after the falling phase begins, well after that. The busy state is sampled within a few tens of cycles after a storing frame ends, far inside the programming window, and ready is awaited by polling the status for a bounded number of cycles. Array contents are only read after ready, since frames started while busy are dropped.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

  localparam int MEM_BITS = 1024;
  localparam int WORD_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int WORDS    = MEM_BITS / WORD_W;
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int BADDR_W  = WIDX_W + 1;
  localparam int HDR_W    = 2 + BADDR_W;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SUB_LOCK  = 2'b00,
    SUB_FILL  = 2'b01,
    SUB_CLEAR = 2'b10,
    SUB_OPEN  = 2'b11
  } sub_e;

  typedef enum logic [1:0] {
    PK_WRITE,
    PK_ERASE,
    PK_CLEAR,
    PK_FILL
  } prog_e;

  typedef struct packed {
    prog_e               kind;
    logic [BADDR_W-1:0]  addr;
    logic [WORD_W-1:0]   data;
    logic                org;
  } prog_req_t;

  // header length after the start bit: code plus address
  function automatic logic [4:0] hdr_bits(input logic org);
    return org ? 5'(2 + WIDX_W) : 5'(2 + BADDR_W);
  endfunction

  // bit position of the data MSB
  function automatic logic [3:0] msb_pos(input logic org);
    return org ? 4'(WORD_W - 1) : 4'(BYTE_W - 1);
  endfunction

  function automatic logic [WIDX_W-1:0] word_index(input logic org,
                                                   input logic [BADDR_W-1:0] a);
    return org ? a[WIDX_W-1:0] : a[BADDR_W-1:1];
  endfunction

  function automatic logic [BADDR_W-1:0] next_addr(input logic org,
                                                   input logic [BADDR_W-1:0] a);
    return org ? {1'b0, a[WIDX_W-1:0] + WIDX_W'(1)} : a + BADDR_W'(1);
  endfunction

endpackage

// File: rtl/tw_in_sync.sv
module tw_in_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_frame_ctl.sv
module tw_frame_ctl
  import tw_eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              di_s,
  input  logic              org_s,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WIDX_W-1:0] rd_idx,
  output logic              cmd_go,
  output prog_req_t         cmd,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              wr_en_o,
  output logic              in_read_o
);
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE} st_e;

  st_e                st;
  logic               sck_d;
  logic [HDR_W-1:0]   hdr;
  logic [WORD_W-1:0]  dsh;
  logic [4:0]         cnt;
  logic [1:0]         op_q;
  logic [BADDR_W-1:0] addr_q;
  logic               org_q;
  logic               wren;
  logic               armed;
  logic               dout;
  logic [3:0]         opos;

  logic               sck_rise;
  logic [HDR_W-1:0]   hdr_n;
  logic [1:0]         op_n;
  logic [1:0]         sub_n;
  logic [BADDR_W-1:0] addr_n;
  logic               hdr_last;
  logic               data_last;
  logic [WORD_W-1:0]  data_n;
  logic [BYTE_W-1:0]  byte_sel;
  logic [WORD_W-1:0]  word_sel;
  logic [3:0]         bi;
  logic               go_req;
  prog_e              go_kind;

  assign sck_rise  = sck_s & ~sck_d;
  assign hdr_n     = {hdr[HDR_W-2:0], di_s};
  assign data_n    = {dsh[WORD_W-2:0], di_s};
  assign hdr_last  = (st == S_HDR)  && (cnt == hdr_bits(org_q) - 5'd1);
  assign data_last = (st == S_DATA) && (cnt[3:0] == msb_pos(org_q));

  always_comb begin
    op_n   = org_q ? hdr_n[HDR_W-2:HDR_W-3] : hdr_n[HDR_W-1:HDR_W-2];
    sub_n  = org_q ? hdr_n[WIDX_W-1:WIDX_W-2] : hdr_n[BADDR_W-1:BADDR_W-2];
    addr_n = org_q ? {1'b0, hdr_n[WIDX_W-1:0]} : hdr_n[BADDR_W-1:0];
  end

  // read data path: word from the array, byte picked by address bit 0
  assign rd_idx   = word_index(org_q, addr_q);
  assign byte_sel = addr_q[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  assign word_sel = org_q ? rd_word : {{(WORD_W-BYTE_W){1'b0}}, byte_sel};
  assign bi       = msb_pos(org_q) - opos;

  // storing commands requested by the frame just completed
  always_comb begin
    go_req  = 1'b0;
    go_kind = PK_WRITE;
    if (cs_s && sck_rise) begin
      if (hdr_last) begin
        if (op_n == OP_ERASE) begin
          go_req  = 1'b1;
          go_kind = PK_ERASE;
        end else if (op_n == OP_SPECIAL && sub_n == SUB_CLEAR) begin
          go_req  = 1'b1;
          go_kind = PK_CLEAR;
        end
      end else if (data_last) begin
        go_req  = 1'b1;
        go_kind = (op_q == OP_WRITE) ? PK_WRITE : PK_FILL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sck_d  <= 1'b0;
      hdr    <= '0;
      dsh    <= '0;
      cnt    <= '0;
      op_q   <= '0;
      addr_q <= '0;
      org_q  <= 1'b0;
      wren   <= 1'b0;
      armed  <= 1'b0;
      dout   <= 1'b0;
      opos   <= '0;
      cmd_go <= 1'b0;
      cmd    <= '0;
    end else begin
      sck_d  <= sck_s;
      cmd_go <= 1'b0;
      if (go_req && wren) begin
        cmd_go <= 1'b1;
        cmd    <= '{kind: go_kind,
                    addr: (st == S_HDR) ? addr_n : addr_q,
                    data: data_n,
                    org:  org_q};
        armed  <= 1'b1;
      end
      if (!cs_s) begin
        st   <= S_IDLE;
        cnt  <= '0;
        opos <= '0;
        dout <= 1'b0;
      end else if (sck_rise) begin
        case (st)
          S_IDLE: begin
            if (di_s && !busy) begin
              st    <= S_HDR;
              cnt   <= '0;
              hdr   <= '0;
              dsh   <= '0;
              org_q <= org_s;
              armed <= 1'b0;
            end
          end
          S_HDR: begin
            hdr <= hdr_n;
            cnt <= cnt + 5'd1;
            if (hdr_last) begin
              addr_q <= addr_n;
              op_q   <= op_n;
              cnt    <= '0;
              st     <= S_DONE;
              if (op_n == OP_READ) begin
                st   <= S_READ;
                dout <= 1'b0;
                opos <= '0;
              end else if (op_n == OP_WRITE) begin
                st <= S_DATA;
              end else if (op_n == OP_SPECIAL) begin
                if (sub_n == SUB_OPEN) wren <= 1'b1;
                if (sub_n == SUB_LOCK) wren <= 1'b0;
                if (sub_n == SUB_FILL) st <= S_DATA;
              end
            end
          end
          S_DATA: begin
            dsh <= data_n;
            cnt <= cnt + 5'd1;
            if (data_last) st <= S_DONE;
          end
          S_READ: begin
            dout <= word_sel[bi];
            if (opos == msb_pos(org_q)) begin
              opos   <= '0;
              addr_q <= next_addr(org_q, addr_q);
            end else begin
              opos <= opos + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign in_read_o = (st == S_READ);
  assign wr_en_o   = wren;
  assign do_oe_o   = in_read_o || (st == S_IDLE && cs_s && armed);
  assign do_o      = in_read_o ? dout : (do_oe_o & ~busy);
endmodule

// File: rtl/tw_prog_engine.sv
module tw_prog_engine
  import tw_eeprom_pkg::*;
#(
  parameter int T_WRITE_CYC = 400,
  parameter int T_CLEAR_CYC = 600,
  parameter int T_FILL_CYC  = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  prog_req_t         req,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              busy_o,
  output logic              done_o
);
  localparam int TMAX0 = (T_WRITE_CYC > T_CLEAR_CYC) ? T_WRITE_CYC : T_CLEAR_CYC;
  localparam int TMAX  = (TMAX0 > T_FILL_CYC) ? TMAX0 : T_FILL_CYC;
  localparam int CW    = $clog2(TMAX + 1);

  logic [WORD_W-1:0] mem [WORDS];
  logic              busy;
  logic [CW-1:0]     tmr;
  prog_req_t         cur;
  logic [WIDX_W-1:0] widx;
  logic [WORD_W-1:0] fill;

  function automatic logic [CW-1:0] dur(input prog_e k);
    case (k)
      PK_CLEAR: return CW'(T_CLEAR_CYC - 1);
      PK_FILL:  return CW'(T_FILL_CYC - 1);
      default:  return CW'(T_WRITE_CYC - 1);
    endcase
  endfunction

  assign widx   = word_index(cur.org, cur.addr);
  assign fill   = cur.org ? cur.data : {2{cur.data[BYTE_W-1:0]}};
  assign done_o = busy && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
      cur  <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (go && !busy) begin
      cur  <= req;
      busy <= 1'b1;
      tmr  <= dur(req.kind);
      // fill: erase phase first
      if (req.kind == PK_FILL)
        for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (busy) begin
      if (tmr != '0) begin
        tmr <= tmr - CW'(1);
      end else begin
        busy <= 1'b0;
        case (cur.kind)
          PK_WRITE: begin
            if (cur.org)          mem[widx] <= cur.data;
            else if (cur.addr[0]) mem[widx][WORD_W-1:BYTE_W] <= cur.data[BYTE_W-1:0];
            else                  mem[widx][BYTE_W-1:0] <= cur.data[BYTE_W-1:0];
          end
          PK_ERASE: begin
            if (cur.org)          mem[widx] <= '1;
            else if (cur.addr[0]) mem[widx][WORD_W-1:BYTE_W] <= '1;
            else                  mem[widx][BYTE_W-1:0] <= '1;
          end
          PK_CLEAR: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
          default:  for (int i = 0; i < WORDS; i++) mem[i] <= fill;
        endcase
      end
    end
  end

  assign rd_word = mem[rd_idx];
  assign busy_o  = busy;
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_WRITE_CYC = 400,
  parameter int T_CLEAR_CYC = 600,
  parameter int T_FILL_CYC  = 1200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  logic              cs_s, sck_s, di_s, org_s;
  logic              busy, prog_done, cmd_go, wr_en, in_read;
  prog_req_t         cmd;
  logic [WIDX_W-1:0] rd_idx;
  logic [WORD_W-1:0] rd_word;

  tw_in_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({org_i, di_i, sck_i, cs_i}),
    .q     ({org_s, di_s, sck_s, cs_s})
  );

  tw_frame_ctl u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sck_s     (sck_s),
    .di_s      (di_s),
    .org_s     (org_s),
    .busy      (busy),
    .rd_word   (rd_word),
    .rd_idx    (rd_idx),
    .cmd_go    (cmd_go),
    .cmd       (cmd),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o),
    .wr_en_o   (wr_en),
    .in_read_o (in_read)
  );

  tw_prog_engine #(
    .T_WRITE_CYC (T_WRITE_CYC),
    .T_CLEAR_CYC (T_CLEAR_CYC),
    .T_FILL_CYC  (T_FILL_CYC)
  ) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (cmd_go),
    .req     (cmd),
    .rd_idx  (rd_idx),
    .rd_word (rd_word),
    .busy_o  (busy),
    .done_o  (prog_done)
  );
endmodule

// File: rtl/tw_eeprom_checker.sv
module tw_eeprom_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic do_oe,
  input logic do_o,
  input logic wr_en,
  input logic cmd_go,
  input logic busy,
  input logic in_read,
  input logic prog_done
);
  // R10
  cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && $past(!cs_s)) |-> !do_oe);

  // R5
  locked_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !cmd_go);

  // R8
  go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> busy);

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_go);

  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_read) |-> (do_oe && !do_o));

  // R9
  timed_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prog_done));
endmodule

bind tw_eeprom_slave tw_eeprom_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .do_oe     (do_oe_o),
  .do_o      (do_o),
  .wr_en     (wr_en),
  .cmd_go    (cmd_go),
  .busy      (busy),
  .in_read   (in_read),
  .prog_done (prog_done)
);

// File: tb/tw_eeprom_slave_test.sv
module tw_eeprom_slave_test;
  localparam int TW = 400;
  localparam int TC = 600;
  localparam int TF = 1200;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0, org = 1'b1;
  logic dout, oe;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  tw_eeprom_slave #(.T_WRITE_CYC(TW), .T_CLEAR_CYC(TC), .T_FILL_CYC(TF)) uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
    .org_i(org), .do_o(dout), .do_oe_o(oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di = b; wait_n(H);
    sck = 1'b1; wait_n(H);
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic cs_low();
    cs = 1'b0; di = 1'b0; wait_n(8);
  endtask

  // full frame, select dropped at the end
  task automatic frame(input logic o, input logic [1:0] op, input logic [6:0] a,
                       input bit has_data, input logic [15:0] d, input int lead);
    org = o; cs = 1'b1; wait_n(4);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    pulse(1'b1);
    send(32'(op), 2);
    send(32'(a), o ? 6 : 7);
    if (has_data) send(32'(d), o ? 16 : 8);
    cs_low();
  endtask

  task automatic special(input logic [1:0] sub, input bit has_data, input logic [15:0] d);
    frame(1'b1, 2'b00, {1'b0, sub, 4'b0}, has_data, d, 0);
  endtask

  task automatic read_seq(input logic o, input logic [6:0] a, input int n,
                          input logic [15:0] e0, input logic [15:0] e1, input string req);
    logic [15:0] got;
    org = o; cs = 1'b1; wait_n(4);
    pulse(1'b1);
    send(32'h2, 2);
    send(32'(a), o ? 6 : 7);
    chk({req, " dummy oe"}, 32'(oe), 32'd1);
    chk({req, " dummy bit"}, 32'(dout), 32'd0);
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int b = 0; b < (o ? 16 : 8); b++) begin
        pulse(1'b0);
        got = {got[14:0], dout};
      end
      chk({req, " data"}, 32'(got), 32'(k == 0 ? e0 : e1));
    end
    cs_low();
  endtask

  task automatic wait_ready(input string req);
    int t;
    cs = 1'b1; wait_n(6);
    chk({req, " status oe"}, 32'(oe), 32'd1);
    t = 0;
    while (dout !== 1'b1 && t < 2 * TF) begin wait_n(1); t++; end
    chk({req, " ready"}, 32'(dout), 32'd1);
    cs_low();
  endtask

  task automatic t_reset();
    chk("R10 reset oe", 32'(oe), 32'd0);
    org = 1'b1; cs = 1'b1; wait_n(4);
    for (int i = 0; i < 6; i++) pulse(1'b0);
    // R1: zero bits leave the block idle, output still off
    chk("R1 idle clocks oe", 32'(oe), 32'd0);
    cs_low();
    read_seq(1'b1, 7'd0, 1, 16'hFFFF, 16'h0, "R1 read after idle clocks");
  endtask

  task automatic t_locked();
    frame(1'b1, 2'b01, 7'd3, 1'b1, 16'h1111, 0);
    cs = 1'b1; wait_n(6);
    chk("R5 no status when locked", 32'(oe), 32'd0);
    cs_low();
    read_seq(1'b1, 7'd3, 1, 16'hFFFF, 16'h0, "R5 locked write ignored");
  endtask

  task automatic t_write_word();
    special(2'b11, 1'b0, 16'h0);
    frame(1'b1, 2'b01, 7'd5, 1'b1, 16'hA5C3, 5);
    cs = 1'b1; wait_n(6);
    chk("R8 busy oe", 32'(oe), 32'd1);
    chk("R8 busy level", 32'(dout), 32'd0);
    wait_n(TW + 40);
    chk("R8 ready level", 32'(dout), 32'd1);
    cs_low();
    read_seq(1'b1, 7'd5, 1, 16'hA5C3, 16'h0, "R6 R2 word write");
  endtask

  task automatic t_seq_read();
    read_seq(1'b1, 7'd5, 2, 16'hA5C3, 16'hFFFF, "R4 sequential words");
    read_seq(1'b0, 7'd10, 2, 16'h00C3, 16'h00A5, "R3 R4 byte view");
  endtask

  task automatic t_byte_write();
    frame(1'b0, 2'b01, 7'd11, 1'b1, 16'h003C, 0);
    wait_ready("R3 byte write");
    read_seq(1'b1, 7'd5, 1, 16'h3CC3, 16'h0, "R3 high byte placed");
  endtask

  task automatic t_cs_drop();
    frame(1'b1, 2'b01, 7'd7, 1'b1, 16'h5A5A, 0);
    wait_n(TW + 40);
    cs = 1'b1; wait_n(6);
    chk("R9 ready after cs low", 32'(dout), 32'd1);
    cs_low();
    read_seq(1'b1, 7'd7, 1, 16'h5A5A, 16'h0, "R9 write completed");
  endtask

  task automatic t_erase();
    frame(1'b1, 2'b11, 7'd5, 1'b0, 16'h0, 0);
    wait_ready("R6 erase");
    read_seq(1'b1, 7'd5, 1, 16'hFFFF, 16'h0, "R6 erase ones");
  endtask

  task automatic t_abort();
    org = 1'b1; cs = 1'b1; wait_n(4);
    pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b0);
    cs_low();
    chk("R10 oe after abort", 32'(oe), 32'd0);
    read_seq(1'b1, 7'd7, 1, 16'h5A5A, 16'h0, "R10 aborted frame harmless");
  endtask

  task automatic t_fill_clear();
    special(2'b01, 1'b1, 16'h1234);
    wait_ready("R7 fill");
    read_seq(1'b1, 7'd0, 1, 16'h1234, 16'h0, "R7 fill first");
    read_seq(1'b1, 7'd63, 1, 16'h1234, 16'h0, "R7 fill last");
    read_seq(1'b0, 7'd127, 1, 16'h0012, 16'h0, "R7 fill byte view");
    special(2'b10, 1'b0, 16'h0);
    wait_ready("R7 clear");
    read_seq(1'b1, 7'd0, 2, 16'hFFFF, 16'hFFFF, "R7 clear");
  endtask

  task automatic t_disable();
    special(2'b00, 1'b0, 16'h0);
    frame(1'b1, 2'b01, 7'd2, 1'b1, 16'h0000, 0);
    cs = 1'b1; wait_n(6);
    chk("R5 no status after lock", 32'(oe), 32'd0);
    cs_low();
    read_seq(1'b1, 7'd2, 1, 16'hFFFF, 16'h0, "R5 relocked write ignored");
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset();
    t_locked();
    t_write_word();
    t_seq_read();
    t_byte_write();
    t_cs_drop();
    t_erase();
    t_abort();
    t_fill_clear();
    t_disable();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule